// File: doc/BRIEF.md
# Half-Band Rate-Converting FIR Filter

This block is a fixed-coefficient, linear-phase, half-band low-pass FIR filter with 55 effective taps. It works on a single clock and can change the sample rate. It can filter at the input rate. It can interpolate by two, stuffing a zero between accepted samples and producing a result on every clock. It can also decimate by two, taking a sample on every clock and producing one result for every two clocks. Signed 12-bit samples come in, and a full-precision signed accumulator word goes out together with a valid strobe. A separate downstream stage performs rounding, limiting, number format conversion and bus drive.

A two-bit mode code selects the rate mode. A one-bit alignment input sets which clock edges count as the "accept" phase. In the half-band coefficient set, every even offset from the centre is zero, and the centre tap is one half of full scale. The filter folds the symmetric taps, so each pair shares a single multiply, and then sums the 15 products in a pipelined binary tree. This gives a fixed pipeline latency of seven clocks.

Top module: `hb_rate_filter`

## Requirements
- R1: `sample_in` is a 12-bit two's complement value with bit 11 as the sign. The reset `rst` is synchronous and active-high. It clears the tap line, the accept-phase toggle and the pipeline. On the cycle after a reset edge, `acc_valid` is 0 and `acc_out` is 0.
- R2: Mode code 2'b11 (`mode_code[1]`=1, `mode_code[0]`=1) is equal rate. `sample_in` enters the tap line on every edge, and `align` has no effect. Once the pipeline has filled, `acc_valid` is 1 on every cycle.
- R3: The result is the sum over tap positions of coefficient times sample, at a gain of 32768 per unit of DC input. The coefficients are symmetric about the centre tap, and the centre tap is 16384. Even offsets other than 0 are zero. The odd offsets ±1, ±3, …, ±27 carry 10355, -3300, 1850, -1180, 800, -560, 390, -270, 180, -115, 70, -40, 20 and -8, in that order.
- R4: Suppose an impulse is loaded at clock edge t. The term for the outermost tap appears on `acc_out` after edge t+7. The centre term (the peak) appears after edge t+34, and the last term appears after edge t+61. After edge t+62, the impulse no longer contributes.
- R5: Mode code 2'b10 is interpolate at half gain. A sample is accepted only on an accept-phase edge, and a zero is shifted in on every other edge. A result with the plain sum is valid on every cycle.
- R6: In the interpolate and decimate modes, an edge with `align`=1 accepts nothing and makes the next edge with `align`=0 an accept edge. After that, accept edges alternate. Holding `align` low from reset, or toggling it on each clock, gives the same sequence.
- R7: Mode code 2'b01 is decimate. A sample enters on every edge. `acc_valid` is 1 only for results whose newest sample came in on an accept edge, so it is never high on two consecutive cycles. `acc_out` holds its value while `acc_valid` is 0.
- R8: The meaning of mode code 2'b00 depends on parameter `ZERO_CODE_UNITY`. When it is 0, code 2'b00 is equal rate. When it is 1, code 2'b00 is interpolate with the result doubled (unity gain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | DATA_W (12) | Signed input sample |
| mode_code | input | 2 | Rate mode code (see R2, R5, R7, R8) |
| align | input | 1 | Accept-phase alignment |
| acc_out | output | ACC_W (32) | Signed full-precision filter result |
| acc_valid | output | 1 | High on cycles carrying a real result |

## Verification
The hardest case to reach is re-alignment in decimate mode. An `align` pulse arrives in the middle of a free-running stream, the output phase slips by one clock, and the bench must show which edge's data now lands in the valid slot. To reach this, the stimulus first flushes the tap line with zeros. It then pulses `align` for one edge, places a single impulse on the following edge, and checks that the valid slot seven clocks later carries exactly that impulse times the outermost coefficient. The slot before it must be invalid. The same flush-then-impulse pattern pins down the 7/34/61 response timing, and a constant full-scale negative input checks the DC gain.

// File: rtl/hb_pkg.sv
package hb_pkg;

  localparam int HB_TAPS    = 55;
  localparam int HB_MID     = (HB_TAPS - 1) / 2;
  localparam int HB_SIDE    = (HB_MID + 1) / 2;
  localparam int HB_CENTRE  = 16384;

  typedef enum logic [1:0] {
    OP_EQUAL  = 2'd0,
    OP_INTERP = 2'd1,
    OP_DECIM  = 2'd2
  } hb_op_e;

  typedef struct packed {
    hb_op_e op;
    logic   dbl;
  } hb_mode_t;

  // Mode code: bit 1 is the first mode pin, bit 0 the second.
  function automatic hb_mode_t decode_mode(input logic [1:0] code, input bit zero_unity);
    hb_mode_t m;
    case (code)
      2'b01:   begin m.op = OP_DECIM;  m.dbl = 1'b0; end
      2'b10:   begin m.op = OP_INTERP; m.dbl = 1'b0; end
      2'b11:   begin m.op = OP_EQUAL;  m.dbl = 1'b0; end
      default: begin
        m.op  = zero_unity ? OP_INTERP : OP_EQUAL;
        m.dbl = zero_unity;
      end
    endcase
    return m;
  endfunction

  // Coefficient at odd offset 2*s+1 from the centre tap.
  function automatic int side_coef(input int s);
    case (s)
      0:  return 10355;
      1:  return -3300;
      2:  return 1850;
      3:  return -1180;
      4:  return 800;
      5:  return -560;
      6:  return 390;
      7:  return -270;
      8:  return 180;
      9:  return -115;
      10: return 70;
      11: return -40;
      12: return 20;
      13: return -8;
      default: return 0;
    endcase
  endfunction

  // Term index s < HB_SIDE is a folded pair; s == HB_SIDE is the centre.
  function automatic int term_coef(input int s);
    return (s < HB_SIDE) ? side_coef(s) : HB_CENTRE;
  endfunction

endpackage

// File: rtl/hb_phase_ctrl.sv
module hb_phase_ctrl
  import hb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   align,
  input  hb_op_e op,
  output logic   accept,
  output logic   token
);

  logic odd_q;

  always_comb begin
    accept = (op == OP_EQUAL) || (!align && !odd_q);
    token  = (op != OP_DECIM) || accept;
  end

  always_ff @(posedge clk) begin
    if (rst)        odd_q <= 1'b0;
    else if (align) odd_q <= 1'b0;
    else            odd_q <= !odd_q;
  end

endmodule

// File: rtl/hb_tapline.sv
module hb_tapline #(
  parameter int DATA_W = 12,
  parameter int TAPS   = 55
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sample,
  input  logic                     accept,
  input  logic                     zero_fill,
  input  logic                     token,
  output logic signed [DATA_W-1:0] taps [TAPS],
  output logic                     tok_q
);

  logic signed [DATA_W-1:0] shift_in;

  always_comb shift_in = (zero_fill && !accept) ? '0 : sample;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
      tok_q <= 1'b0;
    end else begin
      taps[0] <= shift_in;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
      tok_q <= token;
    end
  end

endmodule

// File: rtl/hb_fold_mac.sv
module hb_fold_mac
  import hb_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] taps [HB_TAPS],
  input  logic                     tok_q,
  input  logic                     dbl,
  output logic signed [ACC_W-1:0]  acc,
  output logic                     acc_valid
);

  localparam int TERMS  = HB_SIDE + 1;
  localparam int LEVELS = $clog2(TERMS);
  localparam int LEAVES = 1 << LEVELS;
  localparam int FOLD_W = DATA_W + 1;

  function automatic logic signed [ACC_W-1:0] scale(input logic signed [ACC_W-1:0] v,
                                                    input logic d);
    return d ? (v <<< 1) : v;
  endfunction

  logic signed [FOLD_W-1:0] fold_q [TERMS];
  logic signed [ACC_W-1:0]  prod_q [LEAVES];
  logic [LEVELS+1:0]        vp;

  // Stage 1: pre-add mirrored taps around the centre.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TERMS; k++) fold_q[k] <= '0;
    end else begin
      for (int k = 0; k < TERMS; k++) begin
        if (k < HB_SIDE)
          fold_q[k] <= FOLD_W'(taps[HB_MID-1-2*k]) + FOLD_W'(taps[HB_MID+1+2*k]);
        else
          fold_q[k] <= FOLD_W'(taps[HB_MID]);
      end
    end
  end

  // Stage 2: one constant multiply per folded term, pad leaves zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LEAVES; k++) prod_q[k] <= '0;
    end else begin
      for (int k = 0; k < LEAVES; k++) begin
        if (k < TERMS)
          prod_q[k] <= ACC_W'(fold_q[k]) * ACC_W'(term_coef(k));
        else
          prod_q[k] <= '0;
      end
    end
  end

  // Stages 3..: registered binary adder tree.
  genvar L;
  generate
    for (L = 1; L <= LEVELS; L++) begin : lv
      logic signed [ACC_W-1:0] node [LEAVES >> L];
      if (L == 1) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) for (int k = 0; k < (LEAVES >> L); k++) node[k] <= '0;
          else     for (int k = 0; k < (LEAVES >> L); k++) node[k] <= prod_q[2*k] + prod_q[2*k+1];
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) for (int k = 0; k < (LEAVES >> L); k++) node[k] <= '0;
          else     for (int k = 0; k < (LEAVES >> L); k++)
                     node[k] <= lv[L-1].node[2*k] + lv[L-1].node[2*k+1];
        end
      end
    end
  endgenerate

  // Valid token follows the data through fold, multiply and tree.
  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[LEVELS:0], tok_q};
  end

  // Final stage: gain and hold between valid results.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= vp[LEVELS+1];
      if (vp[LEVELS+1]) acc <= scale(lv[LEVELS].node[0], dbl);
    end
  end

endmodule

// File: rtl/hb_rate_filter.sv
module hb_rate_filter
  import hb_pkg::*;
#(
  parameter int DATA_W          = 12,
  parameter int ACC_W           = 32,
  parameter bit ZERO_CODE_UNITY = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sample_in,
  input  logic [1:0]               mode_code,
  input  logic                     align,
  output logic signed [ACC_W-1:0]  acc_out,
  output logic                     acc_valid
);

  hb_mode_t                 mode_w;
  logic                     mode_equal;
  logic                     mode_interp;
  logic                     mode_decim;
  logic                     accept_w;
  logic                     token_w;
  logic                     tok_q_w;
  logic signed [DATA_W-1:0] tap_w [HB_TAPS];

  always_comb begin
    mode_w      = decode_mode(mode_code, ZERO_CODE_UNITY);
    mode_equal  = (mode_w.op == OP_EQUAL);
    mode_interp = (mode_w.op == OP_INTERP);
    mode_decim  = (mode_w.op == OP_DECIM);
  end

  hb_phase_ctrl u_phase (
    .clk    (clk),
    .rst    (rst),
    .align  (align),
    .op     (mode_w.op),
    .accept (accept_w),
    .token  (token_w)
  );

  hb_tapline #(.DATA_W(DATA_W), .TAPS(HB_TAPS)) u_taps (
    .clk       (clk),
    .rst       (rst),
    .sample    (sample_in),
    .accept    (accept_w),
    .zero_fill (mode_interp),
    .token     (token_w),
    .taps      (tap_w),
    .tok_q     (tok_q_w)
  );

  hb_fold_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .taps      (tap_w),
    .tok_q     (tok_q_w),
    .dbl       (mode_w.dbl),
    .acc       (acc_out),
    .acc_valid (acc_valid)
  );

endmodule

// File: rtl/hb_rate_filter_chk.sv
module hb_rate_filter_chk #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mode_equal,
  input logic                     mode_interp,
  input logic                     mode_decim,
  input logic                     accept,
  input logic signed [DATA_W-1:0] tap0,
  input logic signed [DATA_W-1:0] sample_in,
  input logic signed [ACC_W-1:0]  acc_out,
  input logic                     acc_valid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!acc_valid && acc_out == '0));

  // R2
  equal_load_chk: assert property (@(posedge clk) disable iff (rst)
    mode_equal |=> (tap0 == $past(sample_in)));

  // R5
  interp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_interp && accept) |=> !accept);

  // R5
  interp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_interp && !accept) |=> (tap0 == '0));

  // R7
  decim_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_decim && acc_valid) |=> !acc_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !$past(rst)) |-> $stable(acc_out));

endmodule

bind hb_rate_filter hb_rate_filter_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_equal  (mode_equal),
  .mode_interp (mode_interp),
  .mode_decim  (mode_decim),
  .accept      (accept_w),
  .tap0        (tap_w[0]),
  .sample_in   (sample_in),
  .acc_out     (acc_out),
  .acc_valid   (acc_valid)
);

// File: tb/tb_hb_rate_filter.sv
`timescale 1ns/1ps
module tb_hb_rate_filter;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [11:0] din = '0;
  logic [1:0]         mcode = 2'b11;
  logic               align = 1'b0;
  logic signed [31:0] y0, y1;
  logic               v0, v1;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  hb_rate_filter dut (
    .clk(clk), .rst(rst), .sample_in(din), .mode_code(mcode), .align(align),
    .acc_out(y0), .acc_valid(v0));

  hb_rate_filter #(.ZERO_CODE_UNITY(1'b1)) dut_unity (
    .clk(clk), .rst(rst), .sample_in(din), .mode_code(mcode), .align(align),
    .acc_out(y1), .acc_valid(v1));

  // Reference coefficients built from the R3 list.
  int cf [55];
  int sv [14] = '{10355, -3300, 1850, -1180, 800, -560, 390, -270, 180, -115, 70, -40, 20, -8};
  initial begin
    for (int i = 0; i < 55; i++) cf[i] = 0;
    cf[27] = 16384;
    for (int s = 0; s < 14; s++) begin
      cf[27 - (2*s+1)] = sv[s];
      cf[27 + (2*s+1)] = sv[s];
    end
  end

  // Behavioural reference: history of shifted values, newest at index 0.
  int     hist [2][62];
  bit     tk   [2][62];
  int     ph   [2];
  longint ey   [2];
  bit     ev   [2];
  int     opm, acc_m, val_m;
  bit     dbl_m;
  longint s_m;

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        for (int i = 0; i < 62; i++) begin hist[v][i] = 0; tk[v][i] = 0; end
        ph[v] = 0; ey[v] = 0; ev[v] = 0;
      end else begin
        dbl_m = 0;
        case (mcode)
          2'b01: opm = 2;
          2'b10: opm = 1;
          2'b11: opm = 0;
          default: begin opm = (v == 1) ? 1 : 0; dbl_m = (v == 1); end
        endcase
        acc_m = (opm == 0) ? 1 : ((!align && ph[v] == 0) ? 1 : 0);
        ph[v] = align ? 0 : 1 - ph[v];
        val_m = (opm == 1 && acc_m == 0) ? 0 : int'(din);
        for (int i = 61; i > 0; i--) begin hist[v][i] = hist[v][i-1]; tk[v][i] = tk[v][i-1]; end
        hist[v][0] = val_m;
        tk[v][0]   = (opm == 2) ? (acc_m == 1) : 1'b1;
        s_m = 0;
        for (int i = 0; i < 55; i++) s_m += longint'(cf[i]) * longint'(hist[v][7+i]);
        if (dbl_m) s_m = s_m * 2;
        ev[v] = tk[v][7];
        if (tk[v][7]) ey[v] = s_m;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(v0 == ev[0], cur_req, longint'(v0), longint'(ev[0]));
      chk(longint'(y0) == ey[0], cur_req, longint'(y0), ey[0]);
      chk(v1 == ev[1], cur_req, longint'(v1), longint'(ev[1]));
      chk(longint'(y1) == ey[1], cur_req, longint'(y1), ey[1]);
    end
  end

  task automatic start_seg(input logic [1:0] code, input string req);
    @(negedge clk);
    rst = 1'b1; mcode = code; align = 1'b0; din = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(v0 == 1'b0 && y0 == 0, "R1", longint'(y0), 0);
    chk(v1 == 1'b0 && y1 == 0, "R1", longint'(y1), 0);
    cur_req = req;
    rst = 1'b0;
  endtask

  task automatic drive_zeros(input int n);
    for (int i = 0; i < n; i++) begin din = '0; @(negedge clk); end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R2: equal rate, align toggled randomly (ignored)
    start_seg(2'b11, "R2");
    for (int i = 0; i < 100; i++) begin
      din = 12'($urandom); align = 1'($urandom); @(negedge clk);
    end
    align = 1'b0;
    drive_zeros(70);

    // R4: impulse timing
    cur_req = "R4";
    din = 12'sd1000; @(negedge clk); din = '0;
    for (int k = 0; k <= 62; k++) begin
      if (k == 6)  chk(y0 == 0, "R4", longint'(y0), 0);
      if (k == 7)  chk(longint'(y0) == 1000 * cf[0], "R4", longint'(y0), 1000 * cf[0]);
      if (k == 34) chk(longint'(y0) == 1000 * 16384, "R4", longint'(y0), 1000 * 16384);
      if (k == 61) chk(longint'(y0) == 1000 * cf[54], "R4", longint'(y0), 1000 * cf[54]);
      if (k == 62) chk(y0 == 0, "R4", longint'(y0), 0);
      @(negedge clk);
    end

    // R3: DC gain with full-scale negative input
    cur_req = "R3";
    for (int i = 0; i < 70; i++) begin din = -12'sd2048; @(negedge clk); end
    chk(longint'(y0) == -2048 * 32768, "R3", longint'(y0), -2048 * 32768);

    // R5: interpolate, align high two cycles then low with first sample
    start_seg(2'b10, "R5");
    drive_zeros(70);
    align = 1'b1; @(negedge clk); @(negedge clk);
    align = 1'b0; din = 12'sd500; @(negedge clk); din = '0;
    for (int k = 0; k < 34; k++) @(negedge clk);
    chk(longint'(y0) == 500 * 16384, "R6", longint'(y0), 500 * 16384);
    for (int i = 0; i < 150; i++) begin din = 12'($urandom); @(negedge clk); end

    // R6: interpolate with align toggled every clock
    start_seg(2'b10, "R6");
    for (int i = 0; i < 120; i++) begin
      din = 12'($urandom); align = ~align; @(negedge clk);
    end
    align = 1'b0;

    // R7: decimate, align held low
    start_seg(2'b01, "R7");
    for (int i = 0; i < 150; i++) begin din = 12'($urandom); @(negedge clk); end
    drive_zeros(71);
    // R6: re-alignment pulse in the middle of decimation
    cur_req = "R6";
    align = 1'b1; din = '0; @(negedge clk);
    align = 1'b0; din = 12'sd700; @(negedge clk); din = '0;
    for (int k = 0; k < 6; k++) @(negedge clk);
    chk(v0 == 1'b0, "R6", longint'(v0), 0);
    @(negedge clk);
    chk(v0 == 1'b1 && longint'(y0) == 700 * cf[0], "R6", longint'(y0), 700 * cf[0]);
    cur_req = "R7";
    for (int i = 0; i < 60; i++) begin din = 12'($urandom); @(negedge clk); end

    // R8: code 00 is equal rate on dut, unity-gain interpolate on dut_unity
    start_seg(2'b00, "R8");
    for (int i = 0; i < 150; i++) begin din = 12'($urandom); @(negedge clk); end
    drive_zeros(70);
    din = 12'sd300; @(negedge clk); din = '0;
    for (int k = 0; k < 34; k++) @(negedge clk);
    chk(longint'(y1) == 2 * 300 * 16384, "R8", longint'(y1), 2 * 300 * 16384);
    chk(longint'(y0) == 300 * 16384, "R8", longint'(y0), 300 * 16384);
    repeat (5) @(negedge clk);

    finish_run();
  end

endmodule